// File: doc/BRIEF.md
# Write-Once Bus Visibility Control

This block keeps a single control bit whose meaning depends on how the chip is strapped to operate. The operating mode is one of four: single-chip, expanded multiplexed, bootstrap or special test. In the two modes that have an external bus (expanded and special test), the bit decides whether data seen on internal read cycles is also driven onto the external data pins. In the two modes without a bus (single-chip and bootstrap), the same bit decides whether the E clock reaches its pin or the pin is held low.

Software can read the bit at any time. It can change the bit only once after each reset: the first write strobe loads the bit and sets a private lock, and every later write is dropped until the next reset.

The mode input is captured while reset is held and is frozen from the moment reset is released. The reset value of the bit comes from that captured mode. The CPU, the bus timing generator and the external devices sit outside the block. The timing generator supplies the raw E clock and the internal read cycle indication.

Top module: `bus_vis_ctrl`

## Requirements
- R1: After reset is released, the bit reads 1 if the mode captured during reset was special test (mode code 2'b11) and 0 for single-chip (2'b00), expanded (2'b01) or bootstrap (2'b10).
- R2: The first write strobe after reset loads `wr_data_i` into the bit. The new value appears on `rd_data_o` from the cycle after the strobe's clock edge.
- R3: Every write strobe after the first is ignored until the next reset, whatever data it carries.
- R4: `rd_data_o` always shows the stored bit, in every mode and with no read strobe.
- R5: The mode is captured while `rst_n` is low. Changes on `mode_i` after reset release have no effect on any output.
- R6: In single-chip or bootstrap mode, a stored 1 holds `e_pin_o` low, and a stored 0 passes `e_clk_i` to `e_pin_o`.
- R7: In expanded or special test mode, `e_pin_o` follows `e_clk_i` whatever the bit holds.
- R8: `ext_oe_o` is high exactly when reset is released, `int_rd_i` is high, the bit is 1 and the mode is expanded or special test. `ext_data_o` equals `int_data_i` while `ext_oe_o` is high and is zero otherwise.
- R9: While `rst_n` is low, `e_pin_o` follows `e_clk_i` and `ext_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is captured while low |
| mode_i | input | 2 | Operating mode strap: 00 single-chip, 01 expanded, 10 bootstrap, 11 special test |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 1 | Value for the control bit |
| rd_data_o | output | 1 | Current value of the control bit |
| int_rd_i | input | 1 | High during an internal read cycle |
| int_data_i | input | DATA_W | Data of the internal read cycle |
| ext_data_o | output | DATA_W | Data presented to the external data pins |
| ext_oe_o | output | 1 | Output enable for the external data pins |
| e_clk_i | input | 1 | Raw E clock from the timing generator |
| e_pin_o | output | 1 | E clock pin |

## Verification
The E pin, the data pin enable and the data pins are combinational in the stored state and the live inputs, so they are due in the same cycle as `e_clk_i`, `int_rd_i` or `int_data_i` change. A write strobe or a reset changes the stored bit at the next rising edge, so its effect on readback and on the pins is due one cycle later. The bench drives every input one nanosecond after the rising edge. A behavioural model advances on the same edge, and every output is compared at the falling edge, by which time both the registered and the combinational paths have settled.

// File: rtl/bus_vis_pkg.sv
package bus_vis_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } op_mode_e;

  // Modes without an external bus: the bit gates the E pin.
  function automatic logic mode_gates_e(input op_mode_e m);
    return (m == MODE_SINGLE) || (m == MODE_BOOT);
  endfunction

  // Modes with an external bus: the bit enables read visibility.
  function automatic logic mode_has_bus(input op_mode_e m);
    return (m == MODE_EXPAND) || (m == MODE_TEST);
  endfunction

  // Value the bit takes while reset is held.
  function automatic logic reset_value(input op_mode_e m);
    return (m == MODE_TEST);
  endfunction

  function automatic logic e_pin_value(input logic in_reset, input op_mode_e m,
                                       input logic vis, input logic e_raw);
    if (in_reset) return e_raw;
    if (mode_gates_e(m) && vis) return 1'b0;
    return e_raw;
  endfunction

  function automatic logic pin_oe_value(input logic in_reset, input op_mode_e m,
                                        input logic vis, input logic rd_cycle);
    return !in_reset && mode_has_bus(m) && vis && rd_cycle;
  endfunction

endpackage

// File: rtl/bus_vis_mode_latch.sv
module bus_vis_mode_latch
  import bus_vis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  output op_mode_e   mode_o
);

  op_mode_e mode_q;

  // Track the strap while reset is low, freeze once it is released.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= op_mode_e'(mode_i);
  end

  assign mode_o = mode_q;

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q)); // R5

endmodule

// File: rtl/bus_vis_once_reg.sv
module bus_vis_once_reg
  import bus_vis_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode_cur,
  input  logic     mode_raw_test,
  input  logic     wr_en_i,
  input  logic     wr_data_i,
  output logic     vis_o,
  output logic     locked_o,
  output logic     wr_take_o
);

  logic vis_q;
  logic done_q;
  logic wr_take;

  // Named event: the one write that is allowed to land.
  assign wr_take = wr_en_i && !done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vis_q  <= mode_raw_test;
      done_q <= 1'b0;
    end else if (wr_take) begin
      vis_q  <= wr_data_i;
      done_q <= 1'b1;
    end
  end

  assign vis_o     = vis_q;
  assign locked_o  = done_q;
  assign wr_take_o = wr_take;

  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vis_q == reset_value(mode_cur))); // R1

  AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !done_q) |=> (vis_q == $past(wr_data_i))); // R2

  AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> ($stable(vis_q) && done_q)); // R3

endmodule

// File: rtl/bus_vis_pin_ctrl.sv
module bus_vis_pin_ctrl
  import bus_vis_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_mode_e          mode_cur,
  input  logic              vis_i,
  input  logic              int_rd_i,
  input  logic [DATA_W-1:0] int_data_i,
  input  logic              e_clk_i,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_oe_o,
  output logic              e_pin_o
);

  logic in_reset;
  logic oe;
  logic e_blocked;

  assign in_reset  = !rst_n;
  assign oe        = pin_oe_value(in_reset, mode_cur, vis_i, int_rd_i);
  assign e_blocked = !in_reset && mode_gates_e(mode_cur) && vis_i;

  assign ext_oe_o   = oe;
  assign ext_data_o = oe ? int_data_i : '0;
  assign e_pin_o    = e_pin_value(in_reset, mode_cur, vis_i, e_clk_i);

  AST_E_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_i && mode_gates_e(mode_cur)) |-> !e_pin_o); // R6

  AST_E_RUNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_has_bus(mode_cur) |-> (e_pin_o == e_clk_i)); // R7

  AST_OE_ONLY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_oe_o |-> (mode_has_bus(mode_cur) && vis_i && int_rd_i)); // R8

  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_oe_o |-> (ext_data_o == '0)); // R8

  AST_GATE_CONSIST: assert property (@(posedge clk) disable iff (!rst_n)
    e_blocked |-> !ext_oe_o); // R8

endmodule

// File: rtl/bus_vis_ctrl.sv
module bus_vis_ctrl
  import bus_vis_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              wr_en_i,
  input  logic              wr_data_i,
  output logic              rd_data_o,
  input  logic              int_rd_i,
  input  logic [DATA_W-1:0] int_data_i,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_oe_o,
  input  logic              e_clk_i,
  output logic              e_pin_o
);

  op_mode_e mode_cur;
  logic     vis;
  logic     locked;
  logic     wr_take;
  logic     mode_raw_test;

  assign mode_raw_test = reset_value(op_mode_e'(mode_i));

  bus_vis_mode_latch u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .mode_o (mode_cur)
  );

  bus_vis_once_reg u_bit (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_cur      (mode_cur),
    .mode_raw_test (mode_raw_test),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .vis_o         (vis),
    .locked_o      (locked),
    .wr_take_o     (wr_take)
  );

  bus_vis_pin_ctrl #(.DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_cur   (mode_cur),
    .vis_i      (vis),
    .int_rd_i   (int_rd_i),
    .int_data_i (int_data_i),
    .e_clk_i    (e_clk_i),
    .ext_data_o (ext_data_o),
    .ext_oe_o   (ext_oe_o),
    .e_pin_o    (e_pin_o)
  );

  assign rd_data_o = vis;

  AST_READBACK_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data_o) |-> $past(wr_take)); // R4

  AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> locked); // R3

  AST_RESET_PINS: assert property (@(posedge clk)
    !rst_n |-> (!ext_oe_o && (e_pin_o == e_clk_i))); // R9

endmodule

// File: tb/test_bus_vis_ctrl.sv
`timescale 1ns/1ps
module test_bus_vis_ctrl;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          wr_en_i = 1'b0;
  logic          wr_data_i = 1'b0;
  logic          rd_data_o;
  logic          int_rd_i = 1'b0;
  logic [DW-1:0] int_data_i = '0;
  logic [DW-1:0] ext_data_o;
  logic          ext_oe_o;
  logic          e_clk_i = 1'b0;
  logic          e_pin_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit seen_edge = 1'b0;

  // reference model state
  int m_mode = 0;
  int m_bit = 0;
  int m_done = 0;

  always #2.5 clk = ~clk;

  bus_vis_ctrl #(.DATA_W(DW)) i_bus_vis_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .int_rd_i(int_rd_i),
    .int_data_i(int_data_i), .ext_data_o(ext_data_o), .ext_oe_o(ext_oe_o),
    .e_clk_i(e_clk_i), .e_pin_o(e_pin_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model advances with the clock; inputs never change at the edge
  always @(posedge clk) begin
    seen_edge = 1'b1;
    if (!rst_n) begin
      m_mode = int'(mode_i);
      m_bit  = (mode_i == 2'b11) ? 1 : 0;
      m_done = 0;
    end else if (wr_en_i && m_done == 0) begin
      m_bit  = int'(wr_data_i);
      m_done = 1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (seen_edge && !finished) begin
      bit no_bus;
      int exp_e, exp_oe, exp_d;
      no_bus = (m_mode == 0) || (m_mode == 2);
      if (!rst_n) exp_e = int'(e_clk_i);
      else if (no_bus && m_bit == 1) exp_e = 0;
      else exp_e = int'(e_clk_i);
      exp_oe = (rst_n && int_rd_i && m_bit == 1 && !no_bus) ? 1 : 0;
      exp_d  = (exp_oe == 1) ? int'(int_data_i) : 0;
      check(int'(rd_data_o) == m_bit, "R4 readback", int'(rd_data_o), m_bit);
      check(int'(e_pin_o) == exp_e,
            rst_n ? (no_bus ? "R6 e pin" : "R7 e pin") : "R9 e pin in reset",
            int'(e_pin_o), exp_e);
      check(int'(ext_oe_o) == exp_oe, rst_n ? "R8 oe" : "R9 oe in reset",
            int'(ext_oe_o), exp_oe);
      check(int'(ext_data_o) == exp_d, "R8 data", int'(ext_data_o), exp_d);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      e_clk_i = ~e_clk_i;
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n  = 1'b0;
    mode_i = m;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic write_bit(input logic v);
    wr_en_i   = 1'b1;
    wr_data_i = v;
    tick(1);
    wr_en_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000ns;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    tick(2);
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      #1;
      // r1_ reset value per mode
      check(int'(rd_data_o) == ((m == 3) ? 1 : 0), "R1 reset value",
            int'(rd_data_o), (m == 3) ? 1 : 0);
      // R5: disturb the strap after release
      mode_i = ~2'(m);
      int_rd_i = 1'b1;
      int_data_i = 8'hA5 ^ 8'(m);
      tick(3);
      // R2: first write loads the opposite of the reset value
      write_bit((m == 3) ? 1'b0 : 1'b1);
      #1;
      check(int'(rd_data_o) == ((m == 3) ? 0 : 1), "R2 first write",
            int'(rd_data_o), (m == 3) ? 0 : 1);
      tick(4);
      // R3: later writes of both values are dropped
      write_bit((m == 3) ? 1'b1 : 1'b0);
      write_bit((m == 3) ? 1'b1 : 1'b0);
      write_bit((m == 3) ? 1'b0 : 1'b1);
      #1;
      check(int'(rd_data_o) == ((m == 3) ? 0 : 1), "R3 second write ignored",
            int'(rd_data_o), (m == 3) ? 0 : 1);
      // R6/R7/R8 observed by the per-cycle compare while reads come and go
      for (int k = 0; k < 6; k++) begin
        int_rd_i   = k[0];
        int_data_i = 8'(k * 37 + m);
        tick(1);
      end
      int_rd_i = 1'b0;
    end
    // Second pass: bit kept at reset value, then written with the same value.
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      int_rd_i = 1'b1;
      int_data_i = 8'h3C;
      tick(3);
      write_bit((m == 3) ? 1'b1 : 1'b0);
      write_bit((m == 3) ? 1'b0 : 1'b1);
      #1;
      check(int'(rd_data_o) == ((m == 3) ? 1 : 0), "R3 lock after same-value write",
            int'(rd_data_o), (m == 3) ? 1 : 0);
      tick(4);
    end
    // R9: write strobe during reset has no effect; pins pass clock in reset
    rst_n = 1'b0;
    mode_i = 2'b00;
    wr_en_i = 1'b1;
    wr_data_i = 1'b1;
    int_rd_i = 1'b1;
    tick(3);
    wr_en_i = 1'b0;
    rst_n = 1'b1;
    tick(1);
    #1;
    check(int'(rd_data_o) == 0, "R9 write in reset ignored", int'(rd_data_o), 0);
    write_bit(1'b1);
    #1;
    check(int'(e_pin_o) == 0, "R6 e pin held low", int'(e_pin_o), 0);
    tick(4);
    finish_run();
  end

endmodule